// File: doc/BRIEF.md
# Active Power Energy-to-Frequency Converter

This block turns a stream of paired signed voltage and current sample words into energy pulse requests. Every accepted pair is multiplied into an instantaneous power value. The products are summed over fixed blocks of `BLOCK_LEN` samples to form the active power figure for that block. The magnitude of the most recently completed block is then added, once per accepted sample, into two wide phase accumulators. Each accumulator raises a one-cycle pulse request whenever it reaches its per-pulse threshold. One accumulator feeds a slow channel meant for a counter or stepper drive. The other feeds a fast channel meant for calibration. The pulse shaping that follows is outside this block.

A 3-bit scale select sets the pulse rates. Its two low bits pick one of four full-scale rates for the slow channel, each double the one before. The top bit picks the multiple by which the fast channel runs above the slow one. All thresholds are computed at elaboration from the sample rate and the sample widths. A negative-energy flag reports the sign of the held block power and refreshes at a fixed rate counted in samples.

Top module: `energy_pulse_engine`

## Requirements
- R1: While `rstN` is low, and after it is released, `lowPulse`, `calPulse` and `negFlag` are 0 and both energy accumulators, the block sum, the sample counters and the registered scale are cleared.
- R2: Each accepted sample (`sampleValid` high at a clock edge) yields the signed product `voltSample*currSample`. The sum of `BLOCK_LEN` consecutive products forms a block value. A block completed on sample n is first integrated on sample n+1. Until the first block completes, the integrated value is zero, so all-zero power gives no pulses.
- R3: On each accepted sample the slow accumulator adds |block value|. When the sum is at least `TL(k) = BLOCK_LEN * 2^(VOLT_W+CURR_W-2) * SAMPLE_HZ * 2 / 2^k` (k = `freqSel[1:0]`), the block emits one request and keeps `sum - TL(k)`. Otherwise it keeps the sum, so the residue always stays below `TL(k)`. A DC input of `-2^(VOLT_W-1)` on both channels therefore gives 0.5·2^k requests per second.
- R4: The fast accumulator works the same way with threshold `TL(k) / M`, where M is `CAL_MULT_LO` when `freqSel[2]` is 0 and `CAL_MULT_HI` when it is 1.
- R5: A request caused by a sample presented in clock cycle c is high only in cycle c+2. A request never appears unless a sample was accepted two cycles earlier.
- R6: Pulse counts depend only on the magnitude of the block value. Equal-magnitude negative and positive power give the same request counts.
- R7: `negFlag` changes only on the accepted sample that closes each period of `SAMPLE_HZ/SIGN_RATE_HZ` accepted samples. On that sample it takes 1 if the block value held before that sample is negative, and 0 otherwise.
- R8: A change of `freqSel` clears both accumulators in the following edge, discarding their residues. Block state and the sign timebase are kept.
- R9: Clock cycles with `sampleValid` low change no block, accumulator or sign state, so inserting idle cycles between samples does not change any request count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | A sample pair is present this cycle |
| voltSample | input | VOLT_W | Signed voltage sample word |
| currSample | input | CURR_W | Signed current sample word |
| freqSel | input | 3 | Scale select: bits 1:0 slow rate, bit 2 fast multiple |
| lowPulse | output | 1 | One-cycle request on the slow channel |
| calPulse | output | 1 | One-cycle request on the fast calibration channel |
| negFlag | output | 1 | High when the tracked active power is negative |

## Verification
The residue properties assume the parameters keep every threshold at or above the largest per-sample increment, `BLOCK_LEN * 2^(VOLT_W+CURR_W-2)`. They also assume that `freqSel` never changes on a cycle that carries a sample step. The timing properties assume reset is held with `sampleValid` low. The bench uses 8-bit samples, 4-sample blocks and rate multiples of 8 and 1000, so the smallest threshold is twice the largest increment. It moves `freqSel` only on idle cycles and drives samples only while reset is released.

// File: rtl/energy_pulse_pkg.sv
package energy_pulse_pkg;

  localparam int ACC_W = 64;

  // Strobes from the sequencing logic to the arithmetic.
  typedef struct packed {
    logic prodStep;    // a captured product is processed this cycle
    logic blockEnd;    // this product closes a block
    logic signTick;    // this product closes a sign-refresh period
    logic scaleClear;  // scale select differs from its registered copy
  } strobe_t;

  // Slow-channel threshold: energy of one request at a combined full-scale rate of 0.5*2^rateSel Hz.
  function automatic logic [ACC_W-1:0] lowThreshold(input int unsigned blockLen,
                                                    input int unsigned prodShift,
                                                    input int unsigned sampleHz,
                                                    input int unsigned rateSel);
    logic [ACC_W-1:0] t;
    t = ACC_W'(blockLen) << prodShift;
    t = t * ACC_W'(sampleHz);
    t = (t << 1) >> rateSel;
    return t;
  endfunction

  function automatic logic [ACC_W-1:0] calThreshold(input logic [ACC_W-1:0] lowTh,
                                                    input int unsigned mult);
    return lowTh / ACC_W'(mult);
  endfunction

endpackage

// File: rtl/energy_pulse_ctrl.sv
module energy_pulse_ctrl
  import energy_pulse_pkg::*;
#(
  parameter int BLOCK_LEN   = 400,
  parameter int SIGN_PERIOD = 1600,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [SEL_W-1:0] freqSel,
  output strobe_t          strobe,
  output logic [SEL_W-1:0] scaleSel
);

  localparam int BLK_W = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam int SGN_W = (SIGN_PERIOD > 1) ? $clog2(SIGN_PERIOD) : 1;
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLOCK_LEN - 1);
  localparam logic [SGN_W-1:0] SGN_LAST = SGN_W'(SIGN_PERIOD - 1);

  logic             validQ;
  logic [BLK_W-1:0] blockCnt;
  logic [SGN_W-1:0] signCnt;
  logic [SEL_W-1:0] selQ;
  logic             blockWrap;
  logic             signWrap;

  assign blockWrap = (blockCnt == BLK_LAST);
  assign signWrap  = (signCnt == SGN_LAST);

  always_comb begin
    strobe.prodStep   = validQ;
    strobe.blockEnd   = validQ && blockWrap;
    strobe.signTick   = validQ && signWrap;
    strobe.scaleClear = (freqSel != selQ);
  end

  assign scaleSel = selQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      blockCnt <= '0;
      signCnt  <= '0;
      selQ     <= '0;
    end else begin
      validQ <= sampleValid;
      selQ   <= freqSel;
      if (validQ) begin
        blockCnt <= blockWrap ? '0 : blockCnt + 1'b1;
        signCnt  <= signWrap ? '0 : signCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/energy_pulse_datapath.sv
module energy_pulse_datapath
  import energy_pulse_pkg::*;
#(
  parameter int VOLT_W      = 16,
  parameter int CURR_W      = 16,
  parameter int BLOCK_LEN   = 400,
  parameter int SAMPLE_HZ   = 16000,
  parameter int CAL_MULT_LO = 32,
  parameter int CAL_MULT_HI = 2000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [VOLT_W-1:0] voltSample,
  input  logic signed [CURR_W-1:0] currSample,
  input  strobe_t                  strobe,
  input  logic [2:0]               scaleSel,
  output logic                     lowPulse,
  output logic                     calPulse,
  output logic                     negFlag,
  output logic [ACC_W-1:0]         accLow,
  output logic [ACC_W-1:0]         accCal,
  output logic [ACC_W-1:0]         thLow,
  output logic [ACC_W-1:0]         thCal
);

  localparam int PW         = VOLT_W + CURR_W;
  localparam int SW         = PW + $clog2(BLOCK_LEN) + 1;
  localparam int PROD_SHIFT = VOLT_W + CURR_W - 2;

  logic signed [PW-1:0] prodQ;
  logic signed [SW-1:0] prodExt;
  logic signed [SW-1:0] sumQ;
  logic signed [SW-1:0] blockQ;
  logic [SW-1:0]        blockMag;
  logic [ACC_W-1:0]     incr;
  logic [ACC_W-1:0]     sumLow;
  logic [ACC_W-1:0]     sumCal;
  logic                 hitLow;
  logic                 hitCal;
  logic [ACC_W-1:0]     lowTab [4];
  logic [ACC_W-1:0]     calTab [8];

  // Threshold tables, one entry per scale setting.
  for (genvar g = 0; g < 4; g++) begin : g_lowTab
    localparam logic [ACC_W-1:0] TH = lowThreshold(BLOCK_LEN, PROD_SHIFT, SAMPLE_HZ, g);
    assign lowTab[g] = TH;
  end

  for (genvar g = 0; g < 8; g++) begin : g_calTab
    localparam int MULT = (g >= 4) ? CAL_MULT_HI : CAL_MULT_LO;
    localparam logic [ACC_W-1:0] TH =
      calThreshold(lowThreshold(BLOCK_LEN, PROD_SHIFT, SAMPLE_HZ, g % 4), MULT);
    assign calTab[g] = TH;
  end

  assign thLow = lowTab[scaleSel[1:0]];
  assign thCal = calTab[scaleSel];

  // Instantaneous power.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ <= '0;
    end else if (sampleValid) begin
      prodQ <= voltSample * currSample;
    end
  end

  assign prodExt = {{(SW - PW){prodQ[PW-1]}}, prodQ};

  // Block sum and held block value.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ   <= '0;
      blockQ <= '0;
    end else if (strobe.prodStep) begin
      if (strobe.blockEnd) begin
        blockQ <= sumQ + prodExt;
        sumQ   <= '0;
      end else begin
        sumQ <= sumQ + prodExt;
      end
    end
  end

  assign blockMag = blockQ[SW-1] ? SW'(-blockQ) : SW'(blockQ);
  assign incr     = {{(ACC_W - SW){1'b0}}, blockMag};
  assign sumLow   = accLow + incr;
  assign sumCal   = accCal + incr;
  assign hitLow   = (sumLow >= thLow);
  assign hitCal   = (sumCal >= thCal);

  // Phase accumulators with residue kept across requests.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accLow   <= '0;
      accCal   <= '0;
      lowPulse <= 1'b0;
      calPulse <= 1'b0;
    end else begin
      lowPulse <= 1'b0;
      calPulse <= 1'b0;
      if (strobe.scaleClear) begin
        accLow <= '0;
        accCal <= '0;
      end else if (strobe.prodStep) begin
        accLow   <= hitLow ? sumLow - thLow : sumLow;
        accCal   <= hitCal ? sumCal - thCal : sumCal;
        lowPulse <= hitLow;
        calPulse <= hitCal;
      end
    end
  end

  // Sign of the held active power, refreshed on the sign timebase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      negFlag <= 1'b0;
    end else if (strobe.signTick) begin
      negFlag <= blockQ[SW-1];
    end
  end

endmodule

// File: rtl/energy_pulse_engine.sv
module energy_pulse_engine
  import energy_pulse_pkg::*;
#(
  parameter int VOLT_W       = 16,
  parameter int CURR_W       = 16,
  parameter int BLOCK_LEN    = 400,
  parameter int SAMPLE_HZ    = 16000,
  parameter int SIGN_RATE_HZ = 10,
  parameter int CAL_MULT_LO  = 32,
  parameter int CAL_MULT_HI  = 2000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [VOLT_W-1:0] voltSample,
  input  logic signed [CURR_W-1:0] currSample,
  input  logic [2:0]               freqSel,
  output logic                     lowPulse,
  output logic                     calPulse,
  output logic                     negFlag
);

  localparam int SIGN_PERIOD = SAMPLE_HZ / SIGN_RATE_HZ;

  strobe_t          strobe;
  logic [2:0]       scaleSel;
  logic [ACC_W-1:0] accLow;
  logic [ACC_W-1:0] accCal;
  logic [ACC_W-1:0] thLow;
  logic [ACC_W-1:0] thCal;
  logic             stepStb;
  logic             tickStb;
  logic             clearStb;

  assign stepStb  = strobe.prodStep;
  assign tickStb  = strobe.signTick;
  assign clearStb = strobe.scaleClear;

  energy_pulse_ctrl #(
    .BLOCK_LEN  (BLOCK_LEN),
    .SIGN_PERIOD(SIGN_PERIOD),
    .SEL_W      (3)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .freqSel    (freqSel),
    .strobe     (strobe),
    .scaleSel   (scaleSel)
  );

  energy_pulse_datapath #(
    .VOLT_W     (VOLT_W),
    .CURR_W     (CURR_W),
    .BLOCK_LEN  (BLOCK_LEN),
    .SAMPLE_HZ  (SAMPLE_HZ),
    .CAL_MULT_LO(CAL_MULT_LO),
    .CAL_MULT_HI(CAL_MULT_HI)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .voltSample (voltSample),
    .currSample (currSample),
    .strobe     (strobe),
    .scaleSel   (scaleSel),
    .lowPulse   (lowPulse),
    .calPulse   (calPulse),
    .negFlag    (negFlag),
    .accLow     (accLow),
    .accCal     (accCal),
    .thLow      (thLow),
    .thCal      (thCal)
  );

endmodule

// File: rtl/energy_pulse_checker.sv
module energy_pulse_checker
  import energy_pulse_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             lowPulse,
  input logic             calPulse,
  input logic             negFlag,
  input logic             stepStb,
  input logic             tickStb,
  input logic             clearStb,
  input logic [ACC_W-1:0] accLow,
  input logic [ACC_W-1:0] accCal,
  input logic [ACC_W-1:0] thLow,
  input logic [ACC_W-1:0] thCal
);

  p_low_pulse_after_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    lowPulse |-> $past(sampleValid, 2));

  p_cal_pulse_after_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    calPulse |-> $past(sampleValid, 2));

  p_low_residue_r3: assert property (@(posedge clk) disable iff (!rstN)
    accLow < thLow);

  p_cal_residue_r4: assert property (@(posedge clk) disable iff (!rstN)
    accCal < thCal);

  p_neg_moves_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    (negFlag != $past(negFlag)) |-> $past(tickStb));

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearStb) |-> (accLow == '0 && accCal == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!stepStb && !clearStb) |=> ($stable(accLow) && $stable(accCal)));

  p_step_needs_sample_r9: assert property (@(posedge clk) disable iff (!rstN)
    stepStb |-> $past(sampleValid));

endmodule

bind energy_pulse_engine energy_pulse_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .lowPulse   (lowPulse),
  .calPulse   (calPulse),
  .negFlag    (negFlag),
  .stepStb    (stepStb),
  .tickStb    (tickStb),
  .clearStb   (clearStb),
  .accLow     (accLow),
  .accCal     (accCal),
  .thLow      (thLow),
  .thCal      (thCal)
);

// File: tb/tb_energy_pulse_engine.sv
`timescale 1ns/1ps
module tb_energy_pulse_engine;

  localparam int VW   = 8;
  localparam int IW   = 8;
  localparam int BL   = 4;
  localparam int SR   = 8000;
  localparam int SRHZ = 10;
  localparam int MLO  = 8;
  localparam int MHI  = 1000;
  localparam int SP   = SR / SRHZ;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 sampleValid = 1'b0;
  logic signed [VW-1:0] voltSample = '0;
  logic signed [IW-1:0] currSample = '0;
  logic [2:0]           freqSel = 3'd0;
  logic                 lowPulse;
  logic                 calPulse;
  logic                 negFlag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Reference model state (per requirement semantics).
  longint mAccL, mAccC, mSum, mBlock;
  int     mCnt, mSignCnt, curSel;
  bit     mNeg;
  bit     expL0, expL1, expC0, expC1, expN0, expN1;
  int     obsLow, obsCal;

  always #2.5 clk = ~clk;

  energy_pulse_engine #(
    .VOLT_W(VW), .CURR_W(IW), .BLOCK_LEN(BL), .SAMPLE_HZ(SR),
    .SIGN_RATE_HZ(SRHZ), .CAL_MULT_LO(MLO), .CAL_MULT_HI(MHI)
  ) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .voltSample(voltSample), .currSample(currSample), .freqSel(freqSel),
    .lowPulse(lowPulse), .calPulse(calPulse), .negFlag(negFlag)
  );

  function automatic longint thLowOf(int sel);
    longint fs = longint'(1) << (VW + IW - 2);
    return (longint'(BL) * fs * longint'(SR) * 2) / (longint'(1) << (sel % 4));
  endfunction

  function automatic longint thCalOf(int sel);
    return thLowOf(sel) / ((sel >= 4) ? MHI : MLO);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    mAccL = 0; mAccC = 0; mSum = 0; mBlock = 0;
    mCnt = 0; mSignCnt = 0; mNeg = 1'b0;
    expL0 = 0; expL1 = 0; expC0 = 0; expC1 = 0; expN0 = 0; expN1 = 0;
    obsLow = 0; obsCal = 0;
  endtask

  task automatic modelStep(input int v, input int i);
    longint inc;
    inc = (mBlock < 0) ? -mBlock : mBlock;
    mAccL += inc;
    mAccC += inc;
    expL0 = (mAccL >= thLowOf(curSel));
    if (expL0) mAccL -= thLowOf(curSel);
    expC0 = (mAccC >= thCalOf(curSel));
    if (expC0) mAccC -= thCalOf(curSel);
    if (mSignCnt == SP - 1) mNeg = (mBlock < 0);
    mSignCnt = (mSignCnt + 1) % SP;
    mSum += longint'(v) * longint'(i);
    mCnt++;
    if (mCnt == BL) begin
      mBlock = mSum; mSum = 0; mCnt = 0;
    end
  endtask

  task automatic compareOutputs();
    if (lowPulse) obsLow++;
    if (calPulse) obsCal++;
    check(lowPulse == expL1, "R3", "lowPulse in its cycle (R5)", lowPulse, expL1);
    check(calPulse == expC1, "R4", "calPulse in its cycle (R5)", calPulse, expC1);
    check(negFlag == expN1, "R7", "negFlag", negFlag, expN1);
  endtask

  task automatic driveCycle(input bit vld, input int v, input int i);
    @(negedge clk);
    compareOutputs();
    expL1 = expL0; expC1 = expC0; expN1 = expN0;
    sampleValid = vld;
    voltSample  = VW'(v);
    currSample  = IW'(i);
    if (vld) modelStep(v, i);
    else begin expL0 = 0; expC0 = 0; end
    expN0 = mNeg;
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) driveCycle(1'b0, 0, 0);
  endtask

  task automatic setSel(input int s);
    @(negedge clk);
    compareOutputs();
    expL1 = expL0; expC1 = expC0; expN1 = expN0;
    sampleValid = 1'b0;
    freqSel = 3'(s);
    curSel = s;
    mAccL = 0; mAccC = 0;
    expL0 = 0; expC0 = 0; expN0 = mNeg;
  endtask

  task automatic doReset(input int s);
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; freqSel = 3'(s); curSel = s;
    repeat (3) @(negedge clk);
    check(lowPulse == 1'b0 && calPulse == 1'b0, "R1", "pulses in reset",
          {lowPulse, calPulse}, 0);
    check(negFlag == 1'b0, "R1", "negFlag in reset", negFlag, 0);
    modelClear();
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset(3);
    for (int k = 0; k < 20; k++) driveCycle(1'b1, -128, -128);
    doReset(7);
    // R1: after reset no prior block value exists, so the first block gives no request.
    for (int k = 0; k < BL; k++) driveCycle(1'b1, -128, -128);
    drain();
    check(obsCal == 0, "R1", "fast requests in first block after reset", obsCal, 0);
  endtask

  task automatic testZeroPower();
    doReset(7);
    for (int k = 0; k < 200; k++) driveCycle(1'b1, 100, 0);
    drain();
    check(obsLow == 0 && obsCal == 0, "R2", "requests for zero power",
          obsLow + obsCal, 0);
  endtask

  task automatic testDcFullScale();
    doReset(3);
    for (int k = 0; k < 4100; k++) driveCycle(1'b1, -128, -128);
    drain();
    check(obsLow == 2, "R3", "slow requests at DC full scale", obsLow, 2);
    check(obsCal == 16, "R4", "fast requests at DC full scale", obsCal, 16);
  endtask

  task automatic testTiming();
    doReset(7);
    // R5: first fast request comes from sample 5 (presented in drive cycle 5), visible at drive cycle 7.
    for (int k = 0; k < 9; k++) begin
      driveCycle(1'b1, -128, -128);
      if (k == 6) check(calPulse == 1'b0, "R5", "calPulse one cycle early", calPulse, 0);
      if (k == 7) check(calPulse == 1'b1, "R5", "calPulse on time", calPulse, 1);
      if (k == 8) check(calPulse == 1'b0, "R5", "calPulse width", calPulse, 0);
    end
    drain();
  endtask

  task automatic testSignSymmetry();
    int negCount;
    doReset(7);
    for (int k = 0; k < 300; k++) driveCycle(1'b1, -100, 100);
    drain();
    negCount = obsCal;
    check(negCount == 90, "R6", "fast requests, negative power", negCount, 90);
    doReset(7);
    for (int k = 0; k < 300; k++) driveCycle(1'b1, 100, 100);
    drain();
    check(obsCal == negCount, "R6", "fast requests, positive power", obsCal, negCount);
  endtask

  task automatic testGaps();
    int plain;
    doReset(6);
    for (int k = 0; k < 600; k++)
      driveCycle(1'b1, ((k * 37) % 200) - 100, ((k * 53) % 180) - 90);
    drain();
    plain = obsCal;
    check(plain > 0, "R9", "pattern yields requests", plain, 1);
    doReset(6);
    for (int k = 0; k < 600; k++) begin
      driveCycle(1'b1, ((k * 37) % 200) - 100, ((k * 53) % 180) - 90);
      if (k % 3 == 0) driveCycle(1'b0, 55, -77);
      if (k % 5 == 0) begin driveCycle(1'b0, -1, 9); driveCycle(1'b0, 3, 3); end
    end
    drain();
    check(obsCal == plain, "R9", "fast requests with idle gaps", obsCal, plain);
  endtask

  task automatic testSignFlag();
    doReset(0);
    for (int k = 0; k < SP - 1; k++) driveCycle(1'b1, -50, 60);
    drain();
    check(negFlag == 1'b0, "R7", "negFlag before period end", negFlag, 0);
    driveCycle(1'b1, -50, 60);
    drain();
    check(negFlag == 1'b1, "R7", "negFlag after negative period", negFlag, 1);
    for (int k = 0; k < SP - 1; k++) driveCycle(1'b1, 50, 60);
    drain();
    check(negFlag == 1'b1, "R7", "negFlag held inside period", negFlag, 1);
    driveCycle(1'b1, 50, 60);
    drain();
    check(negFlag == 1'b0, "R7", "negFlag after positive period", negFlag, 0);
  endtask

  task automatic testScaleClear();
    doReset(3);
    for (int k = 0; k < 1500; k++) driveCycle(1'b1, -128, -128);
    drain();
    check(obsCal == 5, "R8", "fast requests before scale change", obsCal, 5);
    setSel(7);
    drain();
    for (int k = 0; k < 1000; k++) driveCycle(1'b1, -128, -128);
    drain();
    check(obsLow == 0, "R8", "slow residue discarded on scale change", obsLow, 0);
  endtask

  initial begin
    modelClear();
    curSel = 0;
    testReset();
    testZeroPower();
    testDcFullScale();
    testTiming();
    testSignSymmetry();
    testGaps();
    testSignFlag();
    testScaleClear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule